// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Registers

This block is the software-visible register file of a descriptor-driven DMA dispatcher. It collects live conditions from the engine, such as activity and the occupancy of the descriptor and response queues. It latches error, early-termination and completion events into sticky status bits. It holds the control word that stops the engine, stops descriptor fetching, selects the stop policies and gates the interrupt. It also passes the engine's queue fill levels and sequence numbers through read-only windows.

Software reads and writes 32-bit words over a simple synchronous bus. The bus has a write strobe, a byte address and write data, and read data is returned combinationally from the address. A software reset is requested through the control word. The block then runs a timed reset phase that it reports back until the phase completes.

Top module: `dma_csr_block`

## Requirements
- R1: After reset the control word reads 0, all sticky status bits are 0, irq is 0, and the status word shows only the live engine inputs.
- R2: Status bits 0 to 4 (address 0x00) mirror busy, descriptor-queue empty, descriptor-queue full, response-queue empty and response-queue full. Writing ones to these bits changes nothing.
- R3: The control word at 0x04 holds stop (bit 0), software reset (bit 1), stop-on-error (bit 2), stop-on-early-end (bit 3), interrupt enable (bit 4) and fetch halt (bit 5), and bits 31:6 read 0. eng_stop, irq_en and stop_fetch follow bits 0, 4 and 5. Status bit 5 (stopped) and eng_stop are set while the stop bit is set.
- R4: An error event while stop-on-error is set raises status bit 7 and status bit 5. Without that policy, neither bit is raised.
- R5: An early-end event while stop-on-early-end is set raises status bit 8 and status bit 5. Without that policy, neither bit is raised.
- R6: Any completion, error or early-end event sets status bit 9 (interrupt pending). irq equals bit 9 AND the interrupt enable.
- R7: Writing the status word clears each latched bit among 5, 7, 8 and 9 whose written bit is one, and leaves the others. If an event arrives in the same cycle as the clear, the event wins.
- R8: Writing the control word with bit 1 set starts a reset phase of RST_CYCLES cycles. During that phase status bit 6 and eng_reset are high, the control word reads 0x2, control writes are ignored, sticky bits are cleared and events are ignored. After the phase, bit 1 reads 0.
- R9: Address 0x08 reads {write fill, read fill} in 16-bit halves, 0x0C reads the response fill in its low half, and 0x10 reads {write sequence, read sequence}. Unmapped or unaligned addresses read 0, and writes to the read-only words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_busy | input | 1 | Engine active |
| desc_empty | input | 1 | Descriptor queue empty |
| desc_full | input | 1 | Descriptor queue full |
| resp_empty | input | 1 | Response queue empty |
| resp_full | input | 1 | Response queue full |
| err_evt | input | 1 | Error event pulse |
| early_evt | input | 1 | Early-termination event pulse |
| done_evt | input | 1 | Transfer-complete event pulse |
| rd_fill | input | LVL_W | Read queue fill level |
| wr_fill | input | LVL_W | Write queue fill level |
| resp_fill | input | LVL_W | Response queue fill level |
| rd_seq | input | LVL_W | Read sequence number |
| wr_seq | input | LVL_W | Write sequence number |
| eng_stop | output | 1 | Stop request to the engine |
| eng_reset | output | 1 | Reset request to the engine |
| stop_fetch | output | 1 | Halt descriptor fetching |
| irq_en | output | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with LVL_W = 8 and RST_CYCLES = 5. The narrow level inputs exercise zero-extension into the 16-bit halves of the read-only words. The short reset phase allows every cycle of the phase to be sampled, with a write and an error injected in the middle of it. With these values every live-bit pattern and every writable control value can be swept. Every policy, event and enable combination, and every clear mask over the latched bits, can be covered as well.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int WORD_STATUS = 0;
    localparam int WORD_CTRL   = 1;
    localparam int WORD_FILL   = 2;
    localparam int WORD_RESP   = 3;
    localparam int WORD_SEQ    = 4;

    // status bit positions
    localparam int ST_STOPPED = 5;
    localparam int ST_RESET   = 6;
    localparam int ST_ERR     = 7;
    localparam int ST_EARLY   = 8;
    localparam int ST_IRQ     = 9;

    // control word, bit 0 is the last field
    typedef struct packed {
        logic halt_fetch;
        logic int_en;
        logic pol_early;
        logic pol_err;
        logic sw_rst;
        logic stop;
    } ctrl_t;

    // latched status bits
    typedef struct packed {
        logic stopped;
        logic err;
        logic early;
        logic pend;
    } sticky_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
    import dma_csr_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ctrl_t wval,
    output ctrl_t ctrl,
    output logic  resetting
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        ctrl_t            c;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.c.sw_rst) begin
            if (s_q.cnt == '0) begin
                s_d.c.sw_rst = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (we) begin
            if (wval.sw_rst) begin
                s_d.c        = '0;
                s_d.c.sw_rst = 1'b1;
                s_d.cnt      = CNT_W'(RST_CYCLES - 1);
            end else begin
                s_d.c = wval;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl      = s_q.c;
    assign resetting = s_q.c.sw_rst;

    assert_rst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.c.sw_rst && s_q.cnt != '0) |=> s_q.c.sw_rst);
    assert_rst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.c.sw_rst && s_q.cnt == '0) |=> !s_q.c.sw_rst);
    assert_rst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.c.sw_rst |-> (s_q.c.stop == 1'b0 && s_q.c.int_en == 1'b0 && s_q.c.halt_fetch == 1'b0));
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(RST_CYCLES));
    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !s_q.c.sw_rst && !wval.sw_rst) |=> s_q.c == $past(wval));
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status
    import dma_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       resetting,
    input  logic       pol_err,
    input  logic       pol_early,
    input  logic       err_evt,
    input  logic       early_evt,
    input  logic       done_evt,
    input  logic       clr_we,
    input  logic [3:0] clr_mask,
    output sticky_t    st
);
    sticky_t st_d, st_q;
    logic    any_evt;

    assign any_evt = done_evt | err_evt | early_evt;

    always_comb begin
        st_d = st_q;
        if (resetting) begin
            st_d = '0;
        end else begin
            if (clr_we) st_d = sticky_t'(4'(st_q) & ~clr_mask);
            if (err_evt && pol_err) begin
                st_d.err     = 1'b1;
                st_d.stopped = 1'b1;
            end
            if (early_evt && pol_early) begin
                st_d.early   = 1'b1;
                st_d.stopped = 1'b1;
            end
            if (any_evt) st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    assert_err_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!resetting && err_evt && pol_err) |=> (st_q.err && st_q.stopped));
    assert_early_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!resetting && early_evt && pol_early) |=> (st_q.early && st_q.stopped));
    assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!resetting && any_evt) |=> st_q.pend);
    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!resetting && !any_evt && clr_we && clr_mask[0]) |=> !st_q.pend);
    assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resetting |=> (st_q == '0));
endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       status_word,
    input  logic [31:0]       ctrl_word,
    input  logic [LVL_W-1:0]  rd_fill,
    input  logic [LVL_W-1:0]  wr_fill,
    input  logic [LVL_W-1:0]  resp_fill,
    input  logic [LVL_W-1:0]  rd_seq,
    input  logic [LVL_W-1:0]  wr_seq,
    output logic [31:0]       rdata
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        rdata = '0;
        if (addr[1:0] == 2'b00) begin
            if (word == WORD_W'(WORD_STATUS))     rdata = status_word;
            else if (word == WORD_W'(WORD_CTRL))  rdata = ctrl_word;
            else if (word == WORD_W'(WORD_FILL))  rdata = {16'(wr_fill), 16'(rd_fill)};
            else if (word == WORD_W'(WORD_RESP))  rdata = {16'h0, 16'(resp_fill)};
            else if (word == WORD_W'(WORD_SEQ))   rdata = {16'(wr_seq), 16'(rd_seq)};
        end
    end
endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int LVL_W      = 16,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_busy,
    input  logic              desc_empty,
    input  logic              desc_full,
    input  logic              resp_empty,
    input  logic              resp_full,
    input  logic              err_evt,
    input  logic              early_evt,
    input  logic              done_evt,
    input  logic [LVL_W-1:0]  rd_fill,
    input  logic [LVL_W-1:0]  wr_fill,
    input  logic [LVL_W-1:0]  resp_fill,
    input  logic [LVL_W-1:0]  rd_seq,
    input  logic [LVL_W-1:0]  wr_seq,
    output logic              eng_stop,
    output logic              eng_reset,
    output logic              stop_fetch,
    output logic              irq_en,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;

    ctrl_t             ctrl;
    sticky_t           st;
    logic              resetting;
    logic              aligned;
    logic [WORD_W-1:0] word;
    logic              we_status, we_ctrl;
    logic [3:0]        clr_mask;
    logic              stopped_live;
    logic [31:0]       status_word;
    logic              unused_bits;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign word      = bus_addr[ADDR_W-1:2];
    assign we_status = bus_wr && aligned && (word == WORD_W'(WORD_STATUS));
    assign we_ctrl   = bus_wr && aligned && (word == WORD_W'(WORD_CTRL));
    assign clr_mask  = {bus_wdata[ST_STOPPED], bus_wdata[ST_ERR], bus_wdata[ST_EARLY], bus_wdata[ST_IRQ]};
    assign unused_bits = ^{bus_wdata[31:10], bus_wdata[ST_RESET]};

    dma_csr_ctrl #(.RST_CYCLES(RST_CYCLES)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we_ctrl),
        .wval      (ctrl_t'(bus_wdata[5:0])),
        .ctrl      (ctrl),
        .resetting (resetting)
    );

    dma_csr_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .resetting (resetting),
        .pol_err   (ctrl.pol_err),
        .pol_early (ctrl.pol_early),
        .err_evt   (err_evt),
        .early_evt (early_evt),
        .done_evt  (done_evt),
        .clr_we    (we_status),
        .clr_mask  (clr_mask),
        .st        (st)
    );

    assign stopped_live = ctrl.stop | st.stopped;
    assign status_word  = {22'h0, st.pend, st.early, st.err, resetting, stopped_live,
                           resp_full, resp_empty, desc_full, desc_empty, eng_busy};

    dma_csr_rdmux #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) rdmux_i (
        .addr        (bus_addr),
        .status_word (status_word),
        .ctrl_word   ({26'h0, 6'(ctrl)}),
        .rd_fill     (rd_fill),
        .wr_fill     (wr_fill),
        .resp_fill   (resp_fill),
        .rd_seq      (rd_seq),
        .wr_seq      (wr_seq),
        .rdata       (bus_rdata)
    );

    assign eng_stop   = stopped_live;
    assign eng_reset  = resetting;
    assign stop_fetch = ctrl.halt_fetch;
    assign irq_en     = ctrl.int_en;
    assign irq        = st.pend & ctrl.int_en;

    assert_irq_quiet_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reset |-> !irq);
    assert_stop_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ctrl && !resetting && bus_wdata[0] && !bus_wdata[1]) |=> eng_stop);
    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resetting && we_ctrl) |=> $stable(stop_fetch));
endmodule

// File: tb/dma_csr_block_tb.sv
module dma_csr_block_tb_top;
    localparam int ADDR_W = 5;
    localparam int LVL_W  = 8;
    localparam int RSTC   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic eng_busy = 0, desc_empty = 0, desc_full = 0, resp_empty = 0, resp_full = 0;
    logic err_evt = 0, early_evt = 0, done_evt = 0;
    logic [LVL_W-1:0] rd_fill = '0, wr_fill = '0, resp_fill = '0, rd_seq = '0, wr_seq = '0;
    logic eng_stop, eng_reset, stop_fetch, irq_en, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_csr_block #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
        .desc_empty(desc_empty), .desc_full(desc_full), .resp_empty(resp_empty),
        .resp_full(resp_full), .err_evt(err_evt), .early_evt(early_evt),
        .done_evt(done_evt), .rd_fill(rd_fill), .wr_fill(wr_fill),
        .resp_fill(resp_fill), .rd_seq(rd_seq), .wr_seq(wr_seq),
        .eng_stop(eng_stop), .eng_reset(eng_reset), .stop_fetch(stop_fetch),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic dn, input logic er, input logic ea);
        @(negedge clk);
        done_evt = dn; err_evt = er; early_evt = ea;
        @(negedge clk);
        done_evt = 0; err_evt = 0; early_evt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h00, v); chk("R1 status", v, 32'h0);
        rd(5'h04, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 outputs", {28'h0, eng_stop, eng_reset, stop_fetch, irq_en}, 32'h0);

        // R2 live bits sweep, write-one has no effect
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            {resp_full, resp_empty, desc_full, desc_empty, eng_busy} = 5'(p);
            rd(5'h00, v); chk("R2 live", v, 32'(p));
            wr(5'h00, 32'h1F);
            rd(5'h00, v); chk("R2 w1 ignored", v, 32'(p));
        end
        {resp_full, resp_empty, desc_full, desc_empty, eng_busy} = 5'h0;

        // R3 control sweep
        for (int c = 0; c < 64; c++) begin
            if (c[1]) continue;
            wr(5'h04, 32'hFFFF_FFC0 | 32'(c));
            rd(5'h04, v); chk("R3 ctrl readback", v, 32'(c));
            chk("R3 outputs", {29'h0, eng_stop, irq_en, stop_fetch},
                {29'h0, c[0] ? 1'b1 : 1'b0, c[4] ? 1'b1 : 1'b0, c[5] ? 1'b1 : 1'b0});
            rd(5'h00, v); chk("R3 stopped bit", v & 32'h20, c[0] ? 32'h20 : 32'h0);
        end
        wr(5'h04, 32'h0);

        // R4 R5 R6 policy x event x enable
        for (int pol = 0; pol < 4; pol++) begin
            for (int ev = 0; ev < 3; ev++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [31:0] e;
                    wr(5'h04, 32'((g << 4) | (pol << 2)));
                    wr(5'h00, 32'h3FF);
                    rd(5'h00, v); chk("R7 cleared before event", v & 32'h3A0, 32'h0);
                    pulse(ev == 0, ev == 1, ev == 2);
                    e = 32'h200;
                    if (ev == 1 && pol[0]) e = e | 32'h0A0;
                    if (ev == 2 && pol[1]) e = e | 32'h120;
                    rd(5'h00, v);
                    chk(ev == 1 ? "R4 error policy" : (ev == 2 ? "R5 early policy" : "R6 pending"),
                        v & 32'h3A0, e);
                    chk("R6 irq gate", {31'h0, irq}, 32'(g));
                end
            end
        end

        // R7 clear masks
        wr(5'h04, 32'h0C);
        for (int m = 0; m < 16; m++) begin
            logic [31:0] msk;
            wr(5'h00, 32'h3FF);
            pulse(1'b0, 1'b1, 1'b1);
            rd(5'h00, v); chk("R7 all set", v & 32'h3A0, 32'h3A0);
            msk = (m[0] ? 32'h020 : 0) | (m[1] ? 32'h080 : 0) | (m[2] ? 32'h100 : 0) | (m[3] ? 32'h200 : 0);
            wr(5'h00, msk);
            rd(5'h00, v); chk("R7 selective clear", v & 32'h3A0, 32'h3A0 & ~msk);
        end
        // event in the clear cycle wins
        @(negedge clk);
        bus_wr = 1; bus_addr = 5'h00; bus_wdata = 32'h3FF; done_evt = 1;
        @(negedge clk);
        bus_wr = 0; done_evt = 0;
        rd(5'h00, v); chk("R7 event beats clear", v & 32'h3A0, 32'h200);

        // R8 software reset
        wr(5'h04, 32'h1C);
        pulse(1'b0, 1'b1, 1'b0);
        wr(5'h04, 32'h12);
        for (int k = 0; k < RSTC; k++) begin
            chk("R8 eng_reset high", {31'h0, eng_reset}, 32'h1);
            rd(5'h04, v); chk("R8 ctrl during reset", v, 32'h2);
            rd(5'h00, v); chk("R8 status bit6", v & 32'h40, 32'h40);
            if (k == 1) begin
                bus_wr = 1; bus_addr = 5'h04; bus_wdata = 32'h31; err_evt = 1;
            end
            @(negedge clk);
            bus_wr = 0; err_evt = 0;
        end
        chk("R8 eng_reset low", {31'h0, eng_reset}, 32'h0);
        rd(5'h04, v); chk("R8 ctrl after reset", v, 32'h0);
        rd(5'h00, v); chk("R8 status after reset", v & 32'h3E0, 32'h0);
        wr(5'h04, 32'h10);
        rd(5'h04, v); chk("R8 ctrl usable again", v, 32'h10);

        // R9 read-only windows
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_fill = 8'(i * 17); rd_fill = 8'(255 - i * 13);
            resp_fill = 8'(i * 5 + 3); wr_seq = 8'(i * 29); rd_seq = 8'(200 - i * 7);
            rd(5'h08, v); chk("R9 fill", v, {8'h0, 8'(i * 17), 8'h0, 8'(255 - i * 13)});
            rd(5'h0C, v); chk("R9 resp", v, {24'h0, 8'(i * 5 + 3)});
            rd(5'h10, v); chk("R9 seq", v, {8'h0, 8'(i * 29), 8'h0, 8'(200 - i * 7)});
        end
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h08, v); chk("R9 write ignored", v, {16'(wr_fill), 16'(rd_fill)});
        rd(5'h04, v); chk("R9 ctrl untouched", v, 32'h10);
        rd(5'h14, v); chk("R9 unmapped", v, 32'h0);
        rd(5'h1C, v); chk("R9 unmapped top", v, 32'h0);
        rd(5'h05, v); chk("R9 unaligned", v, 32'h0);
        wr(5'h05, 32'h01);
        rd(5'h04, v); chk("R9 unaligned write ignored", v, 32'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule